// File: doc/BRIEF.md
# Unique-Neighbour Path Extension Splitter

This block is one stage of a multistage circuit-switching network. It has M inputs and M outputs. The outputs form two halves: the up half holds outputs 0 to M/2-1 and the down half holds outputs M/2 to M-1. A fixed wiring function links every input to D outputs in each half. When a batch of path requests arrives, the block advances each path by one level. Every path that succeeds claims one output of its requested half, and no two paths ever claim the same output.

The block works in rounds, and each round takes one clock cycle. In a round, every path that has not yet moved proposes to all of its linked outputs in the half it wants. A free output that hears from exactly one proposer accepts that proposer. An output that hears from two or more proposers stays silent, so the block never arbitrates between competing inputs. A path that receives any acceptance takes the lowest-numbered accepting output, and that output is then closed to all later rounds. Rounds continue until every path has moved or a programmable round cap is reached. Any path still waiting at that point is reported as stalled.

Only inputs whose row number is a multiple of the spacing parameter L may start paths. This keeps the stage lightly loaded.

Top module: `uniq_ext_splitter`

## Requirements
- R1: After reset, `busy`, `done`, `granted`, `stalled` and every field of `grant_idx` are 0.
- R2: A launch is a cycle in which `start` is high while `busy` is low. At a launch, `req` and `dir` are captured. Only `req` bits at rows that are a multiple of L (row % L == 0) become paths. Requests at any other row are ignored: such a row is never granted and never stalled.
- R3: The wiring uses H = M/2. Up link k of row i is output (3*i + k*k + 4*k) mod H. Down link k of row i is output H + ((5*i + k*k + 2*k + 1) mod H). Here k runs from 0 to D-1, and `dir` = 1 selects down. In each round, every pending path proposes to all of its links in its chosen half.
- R4: An output accepts in a round only if it is unclaimed and exactly one pending path proposes to it. An output with two or more proposers accepts nobody in that round.
- R5: A pending path with one or more acceptances becomes granted in that round. Its `grant_idx` field becomes the lowest-numbered accepting output, and only that output becomes claimed. A granted path keeps its grant until the next launch.
- R6: No two granted inputs ever hold the same output number.
- R7: `busy` rises in the cycle after a launch. The first round runs at the next clock edge and each round takes one cycle. `done` is high for exactly one cycle, starting after the final round, and `busy` falls in that same cycle.
- R8: The run ends after the round in which every path is granted, or after `round_cap` rounds, whichever comes first. A cap of 0 acts as 1. A path that is still pending at the end has its `stalled` bit set.
- R9: While `busy` is high, `start`, `req` and `dir` have no effect on the run in progress or on its results.
- R10: The output granted to a path lies in the half it requested: below H for up (`dir` = 0), and H or above for down (`dir` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a batch when the block is idle |
| req | input | M | Per-row path request |
| dir | input | M | Per-row direction, 1 = down half |
| round_cap | input | CW | Maximum number of rounds (0 acts as 1) |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse after the last round |
| granted | output | M | Row has been extended |
| grant_idx | output | M*log2(M) | Output number held by each row, row i in bits [i*OW +: OW] |
| stalled | output | M | Row was still pending when the run ended |

## Verification
The hardest situation to reach is an output that receives two proposals and so rejects both, while each proposer is still rescued in the same round through a private link. The bench sets this up on purpose with two rows whose up links share two outputs but each keep one of their own. A run with a one-round cap on a fully loaded stage produces stalled rows, and the bench compares which rows stall against its own round-by-round model. Hundreds of random batches with random caps then compare every output of the block against that model on every clock. Between them they cover rejected outputs, outputs closed in earlier rounds, and launches attempted while the block is busy.

// File: rtl/usplit_pkg.sv
package usplit_pkg;
  // Link k of a row into one half of the outputs; result is within [0, half)
  function automatic int unsigned link_of(input logic down, input int unsigned row,
                                          input int unsigned k, input int unsigned half);
    if (down) return (5 * row + k * k + 2 * k + 1) % half;
    else      return (3 * row + k * k + 4 * k) % half;
  endfunction

  // Row may start a path only on the L-spaced grid
  function automatic logic on_grid(input int unsigned row, input int unsigned spacing);
    return (row % spacing) == 0;
  endfunction
endpackage

// File: rtl/usplit_propose.sv
module usplit_propose
  import usplit_pkg::*;
#(
  parameter int M = 16,
  parameter int D = 3
) (
  input  logic [M-1:0]        pend,
  input  logic [M-1:0]        dir_q,
  input  logic [M-1:0]        claimed,
  output logic [M-1:0][M-1:0] prop,
  output logic [M-1:0]        accept
);
  localparam int H = M / 2;

  // Fan-out: row i raises prop[i][o] for every link in its chosen half
  always_comb begin
    prop = '0;
    for (int i = 0; i < M; i++) begin
      for (int k = 0; k < D; k++) begin
        if (pend[i]) begin
          if (dir_q[i]) prop[i][H + int'(link_of(1'b1, i, k, H))] = 1'b1;
          else          prop[i][int'(link_of(1'b0, i, k, H))]     = 1'b1;
        end
      end
    end
  end

  // Per-output proposal count; accept only a lone proposer on a free output
  for (genvar o = 0; o < M; o++) begin : g_out
    logic [M-1:0] column;
    always_comb begin
      for (int i = 0; i < M; i++) column[i] = prop[i][o];
    end
    assign accept[o] = ($countones(column) == 1) && !claimed[o];
  end
endmodule

// File: rtl/usplit_select.sv
module usplit_select #(
  parameter int M  = 16,
  parameter int OW = 4
) (
  input  logic [M-1:0][M-1:0]  prop,
  input  logic [M-1:0]         accept,
  output logic [M-1:0]         hit,
  output logic [M-1:0][OW-1:0] pick
);
  // Scan downward so the lowest accepting output wins
  always_comb begin
    for (int i = 0; i < M; i++) begin
      hit[i]  = 1'b0;
      pick[i] = '0;
      for (int o = M - 1; o >= 0; o--) begin
        if (prop[i][o] && accept[o]) begin
          hit[i]  = 1'b1;
          pick[i] = OW'(o);
        end
      end
    end
  end
endmodule

// File: rtl/usplit_ctrl.sv
module usplit_ctrl #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          all_done,
  input  logic [CW-1:0] round_cap,
  output logic          launch,
  output logic          last,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] rnd_q, cap_q;

  assign launch = start && !busy;
  assign last   = busy && (all_done || ({1'b0, rnd_q} + 1'b1 >= {1'b0, cap_q}));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      rnd_q <= '0;
      cap_q <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy  <= 1'b1;
        rnd_q <= '0;
        cap_q <= (round_cap == '0) ? CW'(1) : round_cap;
      end else if (busy) begin
        rnd_q <= rnd_q + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uniq_ext_splitter.sv
module uniq_ext_splitter
  import usplit_pkg::*;
#(
  parameter int M  = 16,
  parameter int D  = 3,
  parameter int L  = 2,
  parameter int CW = 4,
  localparam int OW = $clog2(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [M-1:0]  req,
  input  logic [M-1:0]  dir,
  input  logic [CW-1:0] round_cap,
  output logic          busy,
  output logic          done,
  output logic [M-1:0]  granted,
  output logic [M*OW-1:0] grant_idx,
  output logic [M-1:0]  stalled
);
  logic [M-1:0]          active_q, dir_q, claimed_q, gnt_q, stall_q;
  logic [M-1:0][OW-1:0]  idx_q, pick;
  logic [M-1:0][M-1:0]   prop;
  logic [M-1:0]          accept, hit, pend, take, gnt_nx, claim_set, grid;
  logic                  launch, last, all_done;

  for (genvar i = 0; i < M; i++) begin : g_grid
    assign grid[i] = on_grid(i, L);
  end

  assign pend     = active_q & ~gnt_q & {M{busy}};
  assign take     = hit & pend;
  assign gnt_nx   = gnt_q | take;
  assign all_done = (active_q & ~gnt_nx) == '0;

  always_comb begin
    claim_set = '0;
    for (int i = 0; i < M; i++)
      if (take[i]) claim_set[pick[i]] = 1'b1;
  end

  usplit_propose #(.M(M), .D(D)) u_prop (
    .pend(pend), .dir_q(dir_q), .claimed(claimed_q), .prop(prop), .accept(accept)
  );

  usplit_select #(.M(M), .OW(OW)) u_sel (
    .prop(prop), .accept(accept), .hit(hit), .pick(pick)
  );

  usplit_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .all_done(all_done),
    .round_cap(round_cap), .launch(launch), .last(last), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= '0;
      dir_q     <= '0;
      claimed_q <= '0;
      gnt_q     <= '0;
      stall_q   <= '0;
      idx_q     <= '0;
    end else if (launch) begin
      active_q  <= req & grid;
      dir_q     <= dir;
      claimed_q <= '0;
      gnt_q     <= '0;
      stall_q   <= '0;
      idx_q     <= '0;
    end else if (busy) begin
      gnt_q     <= gnt_nx;
      claimed_q <= claimed_q | claim_set;
      for (int i = 0; i < M; i++)
        if (take[i]) idx_q[i] <= pick[i];
      if (last) stall_q <= active_q & ~gnt_nx;
    end
  end

  assign granted   = gnt_q;
  assign stalled   = stall_q;
  assign grant_idx = idx_q;
endmodule

// File: rtl/usplit_checker.sv
module usplit_checker #(
  parameter int M  = 16,
  parameter int L  = 2,
  parameter int OW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            start,
  input logic [M-1:0]    granted,
  input logic [M-1:0]    stalled,
  input logic [M-1:0]    active_q,
  input logic [M-1:0]    dir_q,
  input logic [M*OW-1:0] grant_idx
);
  localparam int H = M / 2;
  logic          dup;
  logic [M-1:0]  off_grid;

  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < M; a++)
      for (int b = a + 1; b < M; b++)
        if (granted[a] && granted[b] && grant_idx[a*OW +: OW] == grant_idx[b*OW +: OW])
          dup = 1'b1;
    for (int i = 0; i < M; i++) off_grid[i] = (i % L) != 0;
  end

  a_r6_disjoint: assert property (@(posedge clk) disable iff (!rst_n) !dup);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r7_busy_fall: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r8_stall_excl: assert property (@(posedge clk) disable iff (!rst_n) (stalled & granted) == '0);
  a_r2_grid: assert property (@(posedge clk) disable iff (!rst_n) ((granted | stalled) & off_grid) == '0);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(active_q) && $stable(dir_q)));
  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ((granted & $past(granted)) == $past(granted)));

  for (genvar i = 0; i < M; i++) begin : g_half
    a_r10_half: assert property (@(posedge clk) disable iff (!rst_n)
      granted[i] |-> ((grant_idx[i*OW +: OW] >= OW'(H)) == dir_q[i]));
  end
endmodule

bind uniq_ext_splitter usplit_checker #(.M(M), .L(L), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .start(start),
  .granted(granted), .stalled(stalled), .active_q(active_q), .dir_q(dir_q),
  .grant_idx(grant_idx)
);

// File: tb/tb_uniq_ext_splitter.sv
module tb_uniq_ext_splitter;
  localparam int M = 16, D = 3, L = 2, CW = 4, OW = 4, H = M / 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [M-1:0] req = '0, dir = '0;
  logic [CW-1:0] round_cap = '0;
  logic busy, done;
  logic [M-1:0] granted, stalled;
  logic [M*OW-1:0] grant_idx;

  uniq_ext_splitter #(.M(M), .D(D), .L(L), .CW(CW)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  bit mb, md;
  bit act[M], dm[M], g[M], clm[M], st[M];
  int gi[M], rnd, capm;

  function automatic bit links(int i, int o, bit d);
    for (int k = 0; k < D; k++) begin
      int t = d ? (H + (i * 5 + k * (k + 2) + 1) % H) : ((i * 3 + k * (k + 4)) % H);
      if (t == o) return 1;
    end
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mb = 0; md = 0; rnd = 0; capm = 1;
      for (int i = 0; i < M; i++) begin act[i]=0; dm[i]=0; g[i]=0; clm[i]=0; st[i]=0; gi[i]=0; end
    end else begin
      md = 0;
      if (!mb) begin
        if (start) begin
          mb = 1; rnd = 0; capm = (round_cap == 0) ? 1 : int'(round_cap);
          for (int i = 0; i < M; i++) begin
            act[i] = req[i] && (i % L == 0); dm[i] = dir[i];
            g[i] = 0; clm[i] = 0; st[i] = 0; gi[i] = 0;
          end
        end
      end else begin
        int cnt[M]; bit acc[M], pend[M], alld;
        for (int i = 0; i < M; i++) pend[i] = act[i] && !g[i];
        for (int o = 0; o < M; o++) begin
          cnt[o] = 0;
          for (int i = 0; i < M; i++) if (pend[i] && links(i, o, dm[i])) cnt[o]++;
          acc[o] = (cnt[o] == 1) && !clm[o];
        end
        for (int i = 0; i < M; i++) if (pend[i])
          for (int o = 0; o < M; o++)
            if (!g[i] && acc[o] && links(i, o, dm[i])) begin g[i] = 1; gi[i] = o; clm[o] = 1; end
        rnd++;
        alld = 1;
        for (int i = 0; i < M; i++) if (act[i] && !g[i]) alld = 0;
        if (alld || rnd >= capm) begin
          mb = 0; md = 1;
          for (int i = 0; i < M; i++) st[i] = act[i] && !g[i];
        end
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n && !finished) begin
    logic [M-1:0] eg, es;
    for (int i = 0; i < M; i++) begin eg[i] = g[i]; es[i] = st[i]; end
    chk(busy == mb, "R7 busy", busy, mb);
    chk(done == md, "R7 done", done, md);
    chk(granted == eg, "R5 granted", granted, eg);
    chk(stalled == es, "R8 stalled", stalled, es);
    for (int i = 0; i < M; i++)
      chk(int'(grant_idx[i*OW +: OW]) == gi[i], "R5 grant_idx", grant_idx[i*OW +: OW], gi[i]);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1; errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(logic [M-1:0] r, logic [M-1:0] dv, int cap);
    @(negedge clk);
    start = 1; req = r; dir = dv; round_cap = CW'(cap);
    @(negedge clk);
    start = 0;
    for (int n = 0; n < 40 && !done; n++) @(negedge clk);
  endtask

  function automatic int idx(int i);
    return int'(grant_idx[i*OW +: OW]);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 ctl", {busy, done}, 0);
    chk(granted == 0 && stalled == 0 && grant_idx == 0, "R1 data", granted, 0);
    rst_n = 1;

    // R3/R5: lone up path on row 0 -> links {0,5,4}, lowest 0
    run(16'h0001, 16'h0000, 4);
    chk(granted == 16'h0001 && idx(0) == 0, "R3 up link", idx(0), 0);

    // R3/R10: lone down path on row 0 -> links {9,12}, lowest 9
    run(16'h0001, 16'h0001, 4);
    chk(idx(0) == 9 && idx(0) >= H, "R10 down half", idx(0), 9);

    // R4: rows 0 {0,5,4} and 4 {4,1,0}: outputs 0 and 4 contested
    run(16'h0011, 16'h0000, 4);
    chk(idx(0) == 5, "R4 row0 avoids contested", idx(0), 5);
    chk(idx(4) == 1, "R4 row4 avoids contested", idx(4), 1);

    // R2: off-grid rows ignored
    run(16'h00AA, 16'h0000, 4);
    chk((granted | stalled) == 16'h0000, "R2 off-grid", granted | stalled, 0);

    // R9: start while busy ignored
    @(negedge clk);
    start = 1; req = 16'h0001; dir = 16'h0000; round_cap = 4'd4;
    @(negedge clk);
    req = 16'h0004; dir = 16'h0004;
    @(negedge clk);
    start = 0;
    for (int n = 0; n < 40 && !done; n++) @(negedge clk);
    chk(granted == 16'h0001 && idx(0) == 0, "R9 busy start ignored", granted, 16'h0001);

    // R8: full load, one-round cap; R6 disjoint on full load
    run(16'hFFFF, 16'hF0F0, 1);
    chk((granted | stalled) == 16'h5555, "R8 cap covers all paths", granted | stalled, 16'h5555);
    run(16'hFFFF, 16'h3C3C, 0);
    chk(!busy, "R8 cap zero acts as one", busy, 0);
    run(16'hFFFF, 16'h0F0F, 15);
    begin
      bit clash = 0;
      for (int a = 0; a < M; a++)
        for (int b = a + 1; b < M; b++)
          if (granted[a] && granted[b] && idx(a) == idx(b)) clash = 1;
      chk(!clash, "R6 disjoint outputs", clash, 0);
    end

    // random batches compared every clock
    for (int n = 0; n < 400; n++) begin
      run(16'($urandom), 16'($urandom), int'($urandom % 16));
      repeat (int'($urandom % 2)) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule